// File: doc/BRIEF.md
# Configuration Window Address Decoder

This block owns one 64-bit base-address register that places a memory-mapped configuration window in the physical address space. Software programs the register through a byte-enabled write port. The register holds a window enable, a two-bit size code and the upper base-address bits. From the stored value the block derives the effective, size-aligned base, the window size in bytes and a flag for an unusable size code.

Address lookups arrive with a valid strobe. One cycle later the block reports whether the address fell inside the window. On a hit it splits the address into bus, device, function and register offset. The number of usable bus bits shrinks with the window size. The size code also decides which base bits take part in the comparison, so a smaller window is aligned more finely.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads 0x0000_0000_B000_0001. The window is enabled with size code 00 at base 0xB000_0000. `eff_base` is 0xB000_0000, `win_size` is 0x1000_0000, `len_err` is 0 and `rsp_valid` is 0.
- R2: A write with `wr_en` high updates only the bytes whose `wr_be` bit is set (bit n covers data bits 8n+7..8n). Every other byte keeps its value, and the new value is visible on `reg_rd` from the cycle after the write.
- R3: Register bits 25..3 always read zero, whatever is written to them. Bit 0 (enable), bits 2..1 (size code) and bits 63..26 (base) are writable.
- R4: The size code in bits 2..1 selects the window size: 00 gives 256 MiB (0x1000_0000), 01 gives 128 MiB (0x0800_0000) and 10 gives 64 MiB (0x0400_0000).
- R5: `eff_base` is the register value with every bit below the window size cleared. Bits 27..26 are cleared for 256 MiB, bit 26 is cleared for 128 MiB, and both are kept for 64 MiB. Bits 2..0 are always cleared.
- R6: Size code 11 is reserved. It raises `len_err`, drives `win_size` and `eff_base` to zero and suppresses every hit.
- R7: While register bit 0 is clear, no lookup hits.
- R8: A lookup hits when the enable is set, the size code is valid and the address masked to the window size equals `eff_base`. `rsp_valid` and `rsp_hit` appear exactly one cycle after `req_valid`.
- R9: On a hit, `rsp_dev` is address bits 19..15, `rsp_func` is bits 14..12 and `rsp_off` is bits 11..0. On a miss these outputs and `rsp_bus` are zero.
- R10: On a hit, `rsp_bus` is address bits 27..20 masked to the buses that fit the window: 8 bits for 256 MiB, 7 bits for 128 MiB and 6 bits for 64 MiB.
- R11: A lookup issued in the same cycle as a register write is decoded against the configuration held before that write.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Per-byte write enables |
| wr_data | input | 64 | Register write data |
| reg_rd | output | 64 | Current register contents |
| eff_base | output | 64 | Size-aligned window base |
| win_size | output | 32 | Window size in bytes, zero when reserved |
| len_err | output | 1 | Reserved size code is programmed |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | Physical address to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Address fell inside the window |
| rsp_bus | output | 8 | Decoded bus number |
| rsp_dev | output | 5 | Decoded device number |
| rsp_func | output | 3 | Decoded function number |
| rsp_off | output | 12 | Decoded register offset |

## Verification
The assertions cover the behaviour that can be checked on every cycle:
- the one-cycle response timing;
- no hit while the window is disabled or the size code is reserved;
- zero fields on a miss;
- the bus number staying within the size-dependent mask;
- a power-of-two size with a base aligned to it;
- untouched bytes holding their value.

Only the bench scenarios can show the absolute values:
- the exact reset contents;
- which register bits are read-only;
- the mapping of each size code to its byte count;
- hit boundaries at both edges of the window;
- a write and a lookup in the same cycle resolving against the old configuration.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
package cfgwin_pkg;

    // Address field widths of a configuration access inside the window
    localparam int OFF_W   = 12;
    localparam int FUNC_W  = 3;
    localparam int DEV_W   = 5;
    localparam int FUNC_LSB = OFF_W;
    localparam int DEV_LSB  = OFF_W + FUNC_W;
    localparam int BUS_LSB  = OFF_W + FUNC_W + DEV_W;

    // Register layout (bit positions decoded by neighbouring logic)
    localparam int EN_BIT  = 0;
    localparam int LEN_LSB = 1;
    localparam int RO_LO   = 3;
    localparam int RO_HI   = 25;

    typedef enum logic [1:0] {
        LEN_256M = 2'b00,
        LEN_128M = 2'b01,
        LEN_64M  = 2'b10,
        LEN_RSVD = 2'b11
    } len_code_e;

endpackage

// File: rtl/cfgwin_reg.sv
`timescale 1ns/1ps
module cfgwin_reg import cfgwin_pkg::*; #(
    parameter int                REG_W     = 64,
    parameter logic [REG_W-1:0]  RESET_VAL = 64'h0000_0000_B000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W/8-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] reg_q
);

    localparam int NBYTES = REG_W / 8;
    localparam logic [REG_W-1:0] RO_BITS =
        ((REG_W'(1) << (RO_HI + 1)) - REG_W'(1)) & ~((REG_W'(1) << RO_LO) - REG_W'(1));
    localparam logic [REG_W-1:0] WR_MASK = ~RO_BITS;

    logic [REG_W-1:0] byte_next;
    logic [REG_W-1:0] reg_d;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_next[b*8 +: 8] = (wr_en && wr_be[b])
                                   ? (wr_data[b*8 +: 8] & WR_MASK[b*8 +: 8])
                                   : reg_q[b*8 +: 8];
    end

    always_comb begin
        reg_d = byte_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= RESET_VAL & WR_MASK;
        else        reg_q <= reg_d;
    end

    // R2: without a write strobe the register holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_q));

    // R2: a fully writable top byte takes the written data
    p_top_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[NBYTES-1]) |=> reg_q[REG_W-1 -: 8] == $past(wr_data[REG_W-1 -: 8]));

    // R2: a disabled low byte keeps its value
    p_low_byte_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_be[0] |=> $stable(reg_q[7:0]));

endmodule

// File: rtl/cfgwin_len_decode.sv
`timescale 1ns/1ps
module cfgwin_len_decode import cfgwin_pkg::*; #(
    parameter int REG_W        = 64,
    parameter int WIN_MAX_LOG2 = 28,
    parameter int SIZE_W       = 32
) (
    input  logic [REG_W-1:0]                  cfg,
    output logic                              win_en,
    output logic                              len_err,
    output logic [REG_W-1:0]                  addr_mask,
    output logic [REG_W-1:0]                  eff_base,
    output logic [SIZE_W-1:0]                 win_size,
    output logic [WIN_MAX_LOG2-BUS_LSB-1:0]   bus_mask
);

    localparam int BUS_W = WIN_MAX_LOG2 - BUS_LSB;

    len_code_e code;
    int        shift;

    always_comb begin
        code    = len_code_e'(cfg[LEN_LSB +: 2]);
        win_en  = cfg[EN_BIT];
        len_err = 1'b0;
        shift   = 0;
        case (code)
            LEN_256M: shift = 0;
            LEN_128M: shift = 1;
            LEN_64M:  shift = 2;
            default: begin
                shift   = 0;
                len_err = 1'b1;
            end
        endcase
        addr_mask = ~((REG_W'(1) << (WIN_MAX_LOG2 - shift)) - REG_W'(1));
        if (len_err) begin
            eff_base = '0;
            win_size = '0;
            bus_mask = '0;
        end else begin
            eff_base = cfg & addr_mask;
            win_size = SIZE_W'(1) << (WIN_MAX_LOG2 - shift);
            bus_mask = BUS_W'((1 << (BUS_W - shift)) - 1);
        end
    end

endmodule

// File: rtl/cfgwin_match.sv
`timescale 1ns/1ps
module cfgwin_match import cfgwin_pkg::*; #(
    parameter int REG_W        = 64,
    parameter int WIN_MAX_LOG2 = 28
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [REG_W-1:0]                  req_addr,
    input  logic                              win_en,
    input  logic                              len_err,
    input  logic [REG_W-1:0]                  addr_mask,
    input  logic [REG_W-1:0]                  eff_base,
    input  logic [WIN_MAX_LOG2-BUS_LSB-1:0]   bus_mask,
    output logic                              rsp_valid,
    output logic                              rsp_hit,
    output logic [WIN_MAX_LOG2-BUS_LSB-1:0]   rsp_bus,
    output logic [DEV_W-1:0]                  rsp_dev,
    output logic [FUNC_W-1:0]                 rsp_func,
    output logic [OFF_W-1:0]                  rsp_off
);

    localparam int BUS_W = WIN_MAX_LOG2 - BUS_LSB;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [OFF_W-1:0]  off;
    } match_state_t;

    match_state_t state_d, state_q;
    logic         hit_now;

    always_comb begin
        hit_now = req_valid && win_en && !len_err
               && ((req_addr & addr_mask) == eff_base);
        state_d       = '0;
        state_d.valid = req_valid;
        state_d.hit   = hit_now;
        if (hit_now) begin
            state_d.bus  = req_addr[BUS_LSB +: BUS_W] & bus_mask;
            state_d.dev  = req_addr[DEV_LSB +: DEV_W];
            state_d.func = req_addr[FUNC_LSB +: FUNC_W];
            state_d.off  = req_addr[0 +: OFF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid = state_q.valid;
    assign rsp_hit   = state_q.hit;
    assign rsp_bus   = state_q.bus;
    assign rsp_dev   = state_q.dev;
    assign rsp_func  = state_q.func;
    assign rsp_off   = state_q.off;

    // R8: response strobe trails the request by one cycle
    p_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));

    // R8: a hit is only ever reported with a valid response
    p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R7: disabled window never hits
    p_disabled_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !win_en) |=> !rsp_hit);

    // R6: reserved size code never hits
    p_reserved_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && len_err) |=> !rsp_hit);

    // R9: fields are zero on a miss
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_bus == '0 && rsp_dev == '0 && rsp_func == '0 && rsp_off == '0));

    // R10: bus number stays within the size-dependent range
    p_bus_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_bus & ~$past(bus_mask)) == '0);

endmodule

// File: rtl/cfgwin_decoder.sv
`timescale 1ns/1ps
module cfgwin_decoder import cfgwin_pkg::*; #(
    parameter int               REG_W        = 64,
    parameter logic [REG_W-1:0] RESET_VAL    = 64'h0000_0000_B000_0001,
    parameter int               WIN_MAX_LOG2 = 28,
    parameter int               SIZE_W       = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [REG_W/8-1:0]               wr_be,
    input  logic [REG_W-1:0]                 wr_data,
    output logic [REG_W-1:0]                 reg_rd,
    output logic [REG_W-1:0]                 eff_base,
    output logic [SIZE_W-1:0]                win_size,
    output logic                             len_err,
    input  logic                             req_valid,
    input  logic [REG_W-1:0]                 req_addr,
    output logic                             rsp_valid,
    output logic                             rsp_hit,
    output logic [WIN_MAX_LOG2-BUS_LSB-1:0]  rsp_bus,
    output logic [DEV_W-1:0]                 rsp_dev,
    output logic [FUNC_W-1:0]                rsp_func,
    output logic [OFF_W-1:0]                 rsp_off
);

    localparam int BUS_W = WIN_MAX_LOG2 - BUS_LSB;

    logic [REG_W-1:0] cfg_q;
    logic             win_en;
    logic [REG_W-1:0] addr_mask;
    logic [BUS_W-1:0] bus_mask;

    cfgwin_reg #(
        .REG_W     (REG_W),
        .RESET_VAL (RESET_VAL)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .reg_q   (cfg_q)
    );

    cfgwin_len_decode #(
        .REG_W        (REG_W),
        .WIN_MAX_LOG2 (WIN_MAX_LOG2),
        .SIZE_W       (SIZE_W)
    ) u_len (
        .cfg       (cfg_q),
        .win_en    (win_en),
        .len_err   (len_err),
        .addr_mask (addr_mask),
        .eff_base  (eff_base),
        .win_size  (win_size),
        .bus_mask  (bus_mask)
    );

    cfgwin_match #(
        .REG_W        (REG_W),
        .WIN_MAX_LOG2 (WIN_MAX_LOG2)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .win_en    (win_en),
        .len_err   (len_err),
        .addr_mask (addr_mask),
        .eff_base  (eff_base),
        .bus_mask  (bus_mask),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_bus   (rsp_bus),
        .rsp_dev   (rsp_dev),
        .rsp_func  (rsp_func),
        .rsp_off   (rsp_off)
    );

    assign reg_rd = cfg_q;

    // R4: a valid size code yields a power-of-two window
    p_size_pow2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !len_err |-> $onehot(win_size));

    // R5: the effective base is aligned to the window size
    p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !len_err |-> (eff_base & REG_W'(win_size - SIZE_W'(1))) == '0);

    // R6: reserved code zeroes size and base
    p_reserved_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (win_size == '0 && eff_base == '0));

endmodule

// File: tb/cfgwin_decoder_test.sv
`timescale 1ns/1ps
module cfgwin_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_be = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] reg_rd, eff_base;
    logic [31:0] win_size;
    logic        len_err;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [7:0]  rsp_bus;
    logic [4:0]  rsp_dev;
    logic [2:0]  rsp_func;
    logic [11:0] rsp_off;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] cfg_model = 64'h0000_0000_B000_0001;

    always #2 clk = ~clk;

    cfgwin_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .reg_rd(reg_rd), .eff_base(eff_base), .win_size(win_size), .len_err(len_err),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_bus(rsp_bus), .rsp_dev(rsp_dev),
        .rsp_func(rsp_func), .rsp_off(rsp_off)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] m_mask(input logic [1:0] c);
        case (c)
            2'b01:   return ~64'h07FF_FFFF;
            2'b10:   return ~64'h03FF_FFFF;
            default: return ~64'h0FFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] m_size(input logic [1:0] c);
        case (c)
            2'b00:   return 32'h1000_0000;
            2'b01:   return 32'h0800_0000;
            2'b10:   return 32'h0400_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] m_busmask(input logic [1:0] c);
        case (c)
            2'b00:   return 8'hFF;
            2'b01:   return 8'h7F;
            2'b10:   return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    task automatic reg_write(input logic [7:0] be, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
        for (int b = 0; b < 8; b++)
            if (be[b]) cfg_model[b*8 +: 8] = d[b*8 +: 8];
        cfg_model[25:3] = '0;
    endtask

    task automatic lookup(input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_lookup(input string tag, input logic [63:0] a);
        logic [1:0] c;
        logic       h;
        c = cfg_model[2:1];
        h = cfg_model[0] && (c != 2'b11) && ((a & m_mask(c)) == (cfg_model & m_mask(c)));
        lookup(a);
        chk({tag, " valid R8"}, 64'(rsp_valid), 64'd1);
        chk({tag, " hit R8"}, 64'(rsp_hit), 64'(h));
        chk({tag, " bus R10"}, 64'(rsp_bus), h ? 64'(a[27:20] & m_busmask(c)) : 64'd0);
        chk({tag, " dev R9"}, 64'(rsp_dev), h ? 64'(a[19:15]) : 64'd0);
        chk({tag, " func R9"}, 64'(rsp_func), h ? 64'(a[14:12]) : 64'd0);
        chk({tag, " off R9"}, 64'(rsp_off), h ? 64'(a[11:0]) : 64'd0);
    endtask

    task automatic t_reset();
        chk("reset reg R1", reg_rd, 64'h0000_0000_B000_0001);
        chk("reset base R1", eff_base, 64'h0000_0000_B000_0000);
        chk("reset size R1", 64'(win_size), 64'h1000_0000);
        chk("reset err R1", 64'(len_err), 64'd0);
        chk("reset rsp R1", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_bytes();
        reg_write(8'h01, '1);
        chk("byte0 R2 R3", reg_rd, 64'h0000_0000_B000_0007);
        chk("rsvd err R6", 64'(len_err), 64'd1);
        chk("rsvd size R6", 64'(win_size), 64'd0);
        chk("rsvd base R6", eff_base, 64'd0);
        expect_lookup("rsvd miss R6", 64'h0000_0000_B000_0000);
        reg_write(8'hF0, 64'h1234_5678_0000_0000);
        chk("upper bytes R2", reg_rd, 64'h1234_5678_B000_0007);
        reg_write(8'hFF, 64'h0000_0000_B000_0001);
        reg_write(8'h0E, '1);
        chk("mid bytes R3", reg_rd, 64'h0000_0000_FC00_0001);
    endtask

    task automatic t_lengths();
        for (int c = 0; c < 3; c++) begin
            reg_write(8'hFF, 64'h0000_0000_BFFF_FFF9 | 64'(c << 1));
            chk("ro bits R3", reg_rd, 64'h0000_0000_BC00_0001 | 64'(c << 1));
            chk("size R4", 64'(win_size), 64'(m_size(2'(c))));
            chk("base R5", eff_base, (64'h0000_0000_BC00_0001 | 64'(c << 1)) & m_mask(2'(c)));
            chk("err R6", 64'(len_err), 64'd0);
        end
    endtask

    task automatic t_hits();
        reg_write(8'hFF, 64'h0000_0000_B800_0003);
        expect_lookup("128 low edge R8", 64'h0000_0000_B800_0000);
        expect_lookup("128 fields R9", 64'h0000_0000_B800_0000 | (64'h7F << 20) | (64'h1F << 15) | (64'h7 << 12) | 64'hABC);
        expect_lookup("128 top R8", 64'h0000_0000_BFFF_FFFF);
        expect_lookup("below R8", 64'h0000_0000_B7FF_FFFF);
        expect_lookup("above R8", 64'h0000_0000_C000_0000);
        expect_lookup("high bits R8", 64'h0000_0001_B800_0000);
    endtask

    task automatic t_bus_mask();
        reg_write(8'hFF, 64'h0000_0000_B000_0001);
        expect_lookup("256 bus R10", 64'h0000_0000_B000_0000 | (64'hC5 << 20));
        reg_write(8'hFF, 64'h0000_0000_BC00_0005);
        expect_lookup("64 bus R10", 64'h0000_0000_BC00_0000 | (64'h3A << 20) | (64'h3 << 15) | (64'h5 << 12) | 64'h10);
    endtask

    task automatic t_disable();
        reg_write(8'hFF, 64'h0000_0000_B000_0000);
        expect_lookup("disabled R7", 64'h0000_0000_B010_0000);
    endtask

    task automatic t_same_cycle();
        reg_write(8'hFF, 64'h0000_0000_B000_0001);
        @(negedge clk);
        wr_en = 1'b1; wr_be = 8'hFF; wr_data = 64'h0000_0000_E000_0001;
        req_valid = 1'b1; req_addr = 64'h0000_0000_E000_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; req_valid = 1'b0;
        cfg_model = 64'h0000_0000_E000_0001;
        chk("old cfg used R11", 64'(rsp_hit), 64'd0);
        chk("write landed R11", reg_rd, 64'h0000_0000_E000_0001);
        @(negedge clk);
        chk("valid drops R8", 64'(rsp_valid), 64'd0);
        expect_lookup("new cfg R11", 64'h0000_0000_E000_0000);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(4 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_lengths();
        t_hits();
        t_bus_mask();
        t_disable();
        t_same_cycle();
        report();
        $finish;
    end

endmodule